// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps the return addresses of a small microcontroller core. When the core enters a subroutine, or when an interrupt vectors it away, the program-counter logic raises a push strobe with the 13-bit address to save. When the core leaves through a return, a return that loads a literal, or a return from interrupt, it raises a pop strobe. The address now on top of the stack is always present on a 13-bit output, so the program counter can load it in the same cycle as the pop.

The stack holds eight entries and behaves as a ring. The pointer wraps in both directions and nothing detects or reports running past either end. A ninth push without intervening pops replaces the oldest saved address. A pop with nothing saved shows whatever slot the wrapped pointer selects. The pointer is internal: the block has no path that would let software read or load it, and no other register of the core is touched by its pushes or pops. Reset returns the pointer to slot zero and leaves the stored addresses in place.

Top module: `ret_stack`

## Requirements
- R1: One cycle after a push, the top-of-stack output equals the address that was pushed.
- R2: A pop exposes the address pushed before the one being removed, giving last-in first-out order.
- R3: The stack keeps eight entries of the full 13-bit width: eight pushes followed by pops return the addresses in reverse order, including the all-ones address 0x1FFF.
- R4: After nine pushes v0..v8, the top shows v8, seven pops step through v7 down to v1, and an eighth pop shows v8 again; v0 is lost.
- R5: The pointer wraps modulo 8 in both directions: a pop from slot zero moves the pointer to slot seven, so the output shows the entry in slot six.
- R6: Reset sets the pointer to slot zero without clearing storage: after reset the output shows the entry in slot seven, and the next push writes slot zero.
- R7: When push and pop are raised in the same cycle, only the push takes effect.
- R8: With neither strobe raised, the top-of-stack output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the pointer |
| pushEn | input | 1 | Save pushAddr on top of the stack this cycle |
| pushAddr | input | 13 | Address to save |
| popEn | input | 1 | Remove the top entry this cycle |
| topAddr | output | 13 | Address currently on top of the stack |

## Verification
The block has no status output, so a wrong pointer shows only as a wrong address on topAddr. A pointer stepped in the wrong direction or by the wrong amount shows on the cycle right after the push or pop that caused it. A wrong wrap or a write to the wrong slot may stay hidden until enough pops reach the affected slot, up to eight operations later. The bench therefore runs full-depth and past-depth sequences and checks the output after every single operation.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

  // Strobes passed from the pointer control to the storage datapath.
  typedef struct packed {
    logic writeEn;   // store the incoming address at the write slot
    logic ptrInc;    // pointers move one slot up (push)
    logic ptrDec;    // pointers move one slot down (pop)
  } stkStrobe_t;

  localparam int unsigned DefDepth = 8;
  localparam int unsigned DefAddrW = 13;

endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
  import ret_stack_pkg::*;
#(
  parameter int unsigned DEPTH = DefDepth,
  localparam int unsigned PtrW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pushEn,
  input  logic            popEn,
  output stkStrobe_t      strobe,
  output logic [PtrW-1:0] wrIdx
);

  localparam logic [PtrW-1:0] LastIdx = PtrW'(DEPTH - 1);

  logic [PtrW-1:0] wrPtr;
  logic [PtrW-1:0] wrPtrNext;

  // Push has priority; a pop raised together with a push is dropped.
  always_comb begin
    strobe.writeEn = pushEn;
    strobe.ptrInc  = pushEn;
    strobe.ptrDec  = popEn & ~pushEn;
  end

  always_comb begin
    wrPtrNext = wrPtr;
    if (strobe.ptrInc) begin
      wrPtrNext = (wrPtr == LastIdx) ? '0 : wrPtr + 1'b1;
    end else if (strobe.ptrDec) begin
      wrPtrNext = (wrPtr == '0) ? LastIdx : wrPtr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPtr <= '0;
    else       wrPtr <= wrPtrNext;
  end

  assign wrIdx = wrPtr;

endmodule

// File: rtl/ret_stack_dp.sv
module ret_stack_dp
  import ret_stack_pkg::*;
#(
  parameter int unsigned DEPTH  = DefDepth,
  parameter int unsigned ADDR_W = DefAddrW,
  localparam int unsigned PtrW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  stkStrobe_t        strobe,
  input  logic [PtrW-1:0]   wrIdx,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] rdData
);

  localparam logic [PtrW-1:0] LastIdx = PtrW'(DEPTH - 1);

  logic [ADDR_W-1:0] slot [DEPTH];
  logic [PtrW-1:0]   rdIdx;

  // Storage has no reset: saved addresses survive a pointer reset.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.writeEn && (wrIdx == PtrW'(i))) slot[i] <= wrData;
    end
  end

  // Read index trails the write pointer by one slot, kept as its own
  // register so the output mux is driven without a subtractor.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx <= LastIdx;
    end else if (strobe.ptrInc) begin
      rdIdx <= (rdIdx == LastIdx) ? '0 : rdIdx + 1'b1;
    end else if (strobe.ptrDec) begin
      rdIdx <= (rdIdx == '0) ? LastIdx : rdIdx - 1'b1;
    end
  end

  assign rdData = slot[rdIdx];

endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int unsigned DEPTH  = DefDepth,
  parameter int unsigned ADDR_W = DefAddrW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic              popEn,
  output logic [ADDR_W-1:0] topAddr
);

  localparam int unsigned PtrW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  stkStrobe_t      strobe;
  logic [PtrW-1:0] wrIdx;

  ret_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pushEn (pushEn),
    .popEn  (popEn),
    .strobe (strobe),
    .wrIdx  (wrIdx)
  );

  ret_stack_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrIdx  (wrIdx),
    .wrData (pushAddr),
    .rdData (topAddr)
  );

endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushEn,
  input logic [ADDR_W-1:0] pushAddr,
  input logic              popEn,
  input logic [ADDR_W-1:0] topAddr
);

  AST_PUSH_ON_TOP: assert property (@(posedge clk) disable iff (!rstN)
    pushEn |=> (topAddr == $past(pushAddr))); // R1

  AST_POP_RESTORES: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && $past(rstN) && $past(pushEn) && !$past(popEn))
      |=> (topAddr == $past(topAddr, 2))); // R2

  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && popEn) |=> (topAddr == $past(pushAddr))); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!pushEn && !popEn && $past(rstN)) |=> $stable(topAddr)); // R8

endmodule

bind ret_stack ret_stack_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pushEn   (pushEn),
  .pushAddr (pushAddr),
  .popEn    (popEn),
  .topAddr  (topAddr)
);

// File: tb/ret_stack_bench.sv
module ret_stack_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushEn = 1'b0;
  logic [12:0] pushAddr = '0;
  logic        popEn = 1'b0;
  logic [12:0] topAddr;

  int testCount = 0;
  int failCount = 0;

  always #2 clk = ~clk;

  ret_stack u_ret_stack (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (pushEn),
    .pushAddr (pushAddr),
    .popEn    (popEn),
    .topAddr  (topAddr)
  );

  task automatic check(input string req, input logic [12:0] exp);
    testCount++;
    if (topAddr !== exp) begin
      failCount++;
      $display("FAIL %s: topAddr=%h expected=%h", req, topAddr, exp);
    end
  endtask

  // All tasks start and end at a falling edge; outputs sampled there.
  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doPush(input logic [12:0] v);
    pushEn = 1'b1; pushAddr = v;
    @(negedge clk);
    pushEn = 1'b0;
  endtask

  task automatic doPop();
    popEn = 1'b1;
    @(negedge clk);
    popEn = 1'b0;
  endtask

  task automatic doBoth(input logic [12:0] v);
    pushEn = 1'b1; popEn = 1'b1; pushAddr = v;
    @(negedge clk);
    pushEn = 1'b0; popEn = 1'b0;
  endtask

  task automatic testPush();
    doReset();
    doPush(13'h0AA); check("R1 first push", 13'h0AA);
    doPush(13'h1F00); check("R1 second push", 13'h1F00);
  endtask

  task automatic testLifo();
    doReset();
    doPush(13'h111); doPush(13'h222); doPush(13'h333);
    doPop(); check("R2 pop to middle", 13'h222);
    doPop(); check("R2 pop to bottom", 13'h111);
  endtask

  task automatic testFull();
    doReset();
    for (int i = 0; i < 8; i++) doPush((i == 7) ? 13'h1FFF : 13'(13'h100 + i));
    check("R3 full top all-ones", 13'h1FFF);
    for (int i = 6; i >= 0; i--) begin
      doPop(); check("R3 reverse order", 13'(13'h100 + i));
    end
  endtask

  task automatic testOverwrite();
    doReset();
    for (int i = 0; i < 9; i++) doPush(13'(13'h040 + i));
    check("R4 ninth on top", 13'h048);
    for (int i = 7; i >= 1; i--) begin
      doPop(); check("R4 descend", 13'(13'h040 + i));
    end
    doPop(); check("R4 oldest replaced", 13'h048);
  endtask

  task automatic testUnderflow();
    doReset();
    for (int i = 0; i < 8; i++) doPush(13'(13'h0A0 + i));
    doPop(); check("R5 pop wraps to slot seven", 13'h0A6);
    doPush(13'h0BB); check("R5 push after wrap", 13'h0BB);
    doPop(); doPop(); check("R5 further wrapped pop", 13'h0A5);
  endtask

  task automatic testReset();
    doReset();
    for (int i = 0; i < 8; i++) doPush(13'(13'h300 + i));
    doReset(); check("R6 storage kept, slot seven shown", 13'h307);
    doPush(13'h0CC); check("R6 push after reset", 13'h0CC);
    doPop(); check("R6 pointer was zero", 13'h307);
    doPop(); check("R6 slot six under wrap", 13'h306);
  endtask

  task automatic testBoth();
    doReset();
    doPush(13'h055);
    doBoth(13'h066); check("R7 push wins", 13'h066);
    doPop(); check("R7 pop ignored earlier", 13'h055);
  endtask

  task automatic testIdle();
    doReset();
    doPush(13'h777);
    repeat (5) @(negedge clk);
    check("R8 idle hold", 13'h777);
    pushAddr = 13'h001;
    repeat (3) @(negedge clk);
    check("R8 data without strobe ignored", 13'h777);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    @(negedge clk);
    testPush();
    testLifo();
    testFull();
    testOverwrite();
    testUnderflow();
    testReset();
    testBoth();
    testIdle();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule